// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the reset signals of a chip as its supplies come up. It runs on the slow always-on clock and watches two power-good inputs, one from the backup supply and one from the main supply. Once the backup supply is good, a startup counter must run out before anything is released. The counter gives the slow oscillator time to settle. After that the backup-domain reset is released first, then the processor and peripheral resets as a pair. The external reset pad is held low for a stretch whose length is selected on an input.

Losing the backup supply pulls every reset back at once, without waiting for a clock edge. Losing only the main supply resets the processor and peripheral domains. When the main supply returns, those domains come back out of reset and the cause field reports a wake-up rather than a cold start. Each release is synchronous to the slow clock. Each power-good input passes through a two-stage synchronizer that clears asynchronously.

Top module: `por_reset_seq`

## Requirements
- R1: While `bkup_por_ok` is 0, `bkup_rst_n`, `cpu_rst_n` and `periph_rst_n` are 0, `ext_rst_pulldn` is 1 and `rst_cause` is 0.
- R2: Counting rising clock edges after `bkup_por_ok` rises, `bkup_rst_n` is still 0 after edge STARTUP_CYCLES+1 and becomes 1 at edge STARTUP_CYCLES+2 (two synchronizer edges, then the startup count).
- R3: When the main supply is already good, `cpu_rst_n` and `periph_rst_n` rise together on the third rising edge after `bkup_rst_n` rises, and they are always equal.
- R4: `ext_rst_pulldn` (1 = pull the external reset pad low) falls exactly 2^(`ext_len`+1) rising edges after `bkup_rst_n` rises. With `ext_len` = 0 this is 2 edges, and with `ext_len` = 15 it is 65536 edges.
- R5: After a cold start, with both supplies coming up, `rst_cause` reads 0 (general reset).
- R6: When `bkup_por_ok` falls, all reset outputs assert before the next clock edge, even with `main_por_ok` still at 1.
- R7: When `main_por_ok` falls while the backup supply stays good, `cpu_rst_n` and `periph_rst_n` are 0 from the first rising edge after the fall. `bkup_rst_n` stays 1 and `ext_rst_pulldn` stays 0.
- R8: After such a dip, `cpu_rst_n` and `periph_rst_n` rise on the fifth rising edge after `main_por_ok` returns. `rst_cause` becomes 1 (wake-up) on the edge after that.
- R9: `rst_cause` keeps its previous value through a main-supply dip until the new release. If the main supply first becomes good only after `bkup_rst_n` is released, the release still reports 0.
- R10: A main supply that is not yet good holds back neither `bkup_rst_n` nor the external reset stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| bkup_por_ok | input | 1 | Backup supply power good, asynchronous, 0 = supply lost |
| main_por_ok | input | 1 | Main supply power good, asynchronous, 0 = supply lost |
| ext_len | input | LEN_W | External reset stretch exponent; the pad is held low for 2^(ext_len+1) cycles |
| bkup_rst_n | output | 1 | Backup-domain reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_pulldn | output | 1 | Drive enable for the open-drain external reset pad, 1 = pull low |
| rst_cause | output | 3 | Cause of the last reset: 0 general, 1 wake-up |

## Verification
The hardest situation to reach is the cause field separating a wake-up from a late cold start. Both end with the processor being released after the main supply rises, and only the history before that differs. The bench drops the main supply after a full release, raises it again and checks that the cause stays put until the release edge. It then drops the backup supply, holds the main supply low through a whole new startup and stretch, and checks that the later release reports a general reset. The longest stretch setting is run through to its last cycle so that the top bit of the stretch counter is exercised.

// File: rtl/porseq_pkg.sv
package porseq_pkg;

  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_GENERAL = 3'd0,
    CAUSE_WAKEUP  = 3'd1
  } cause_e;

endpackage

// File: rtl/por_sync.sv
// Power-good synchronizer: clears at once when the supply drops,
// reports good only after STAGES rising edges with the supply present.
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic ok
);

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign ok = q[STAGES-1];

endmodule

// File: rtl/por_delay.sv
// Release timer: once run has been seen high for limit edges, done
// becomes 1 and stays there. Dropping run clears it synchronously,
// and clr_n clears it at once.
module por_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = limit - 1'b1;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == last) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq
  import porseq_pkg::*;
#(
  parameter int STARTUP_CYCLES = 64,
  parameter int HOLD_CYCLES    = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int LEN_W          = 4
) (
  input  logic               clk,
  input  logic               bkup_por_ok,
  input  logic               main_por_ok,
  input  logic [LEN_W-1:0]   ext_len,
  output logic               bkup_rst_n,
  output logic               cpu_rst_n,
  output logic               periph_rst_n,
  output logic               ext_rst_pulldn,
  output logic [CAUSE_W-1:0] rst_cause
);

  localparam int SW = $clog2(STARTUP_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int EW = (2 ** LEN_W) + 1;
  localparam logic [SW-1:0]    START_LIM = SW'(STARTUP_CYCLES);
  localparam logic [HW-1:0]    HOLD_LIM  = HW'(HOLD_CYCLES);
  localparam logic [LEN_W:0]   ONE_SH    = (LEN_W + 1)'(1);
  localparam logic [EW-1:0]    ONE_EXT   = EW'(1);

  logic main_clr_n;
  logic bkup_ok_s;
  logic main_ok_s;
  logic bkup_done;
  logic cpu_done;
  logic ext_done;
  logic cpu_run;
  logic cpu_prev;
  logic main_lost;
  logic [LEN_W:0] ext_shift;
  logic [EW-1:0]  ext_limit;
  cause_e         cause_q;

  // The main-domain synchronizer also clears when the backup supply drops.
  assign main_clr_n = bkup_por_ok & main_por_ok;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync_bkup (
    .clk   (clk),
    .clr_n (bkup_por_ok),
    .ok    (bkup_ok_s)
  );

  por_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
    .clk   (clk),
    .clr_n (main_clr_n),
    .ok    (main_ok_s)
  );

  // Startup filter: oscillator settling before the backup domain is released.
  por_delay #(.CNT_W(SW)) u_startup (
    .clk   (clk),
    .clr_n (bkup_por_ok),
    .run   (bkup_ok_s),
    .limit (START_LIM),
    .done  (bkup_done)
  );

  // Processor and peripheral hold after the backup release, gated by the main supply.
  assign cpu_run = bkup_done & main_ok_s;

  por_delay #(.CNT_W(HW)) u_cpu_hold (
    .clk   (clk),
    .clr_n (bkup_por_ok),
    .run   (cpu_run),
    .limit (HOLD_LIM),
    .done  (cpu_done)
  );

  // External pad stretch of 2^(ext_len+1) cycles, backup domain only.
  assign ext_shift = {1'b0, ext_len} + ONE_SH;
  assign ext_limit = ONE_EXT << ext_shift;

  por_delay #(.CNT_W(EW)) u_ext_stretch (
    .clk   (clk),
    .clr_n (bkup_por_ok),
    .run   (bkup_done),
    .limit (ext_limit),
    .done  (ext_done)
  );

  // Cause tracking: a main-supply loss after a full release marks a wake-up.
  // The code is latched on the edge after the processor release.
  always_ff @(posedge clk or negedge bkup_por_ok) begin
    if (!bkup_por_ok) begin
      cpu_prev  <= 1'b0;
      main_lost <= 1'b0;
      cause_q   <= CAUSE_GENERAL;
    end else begin
      cpu_prev <= cpu_done;
      if (cpu_done && !cpu_prev) begin
        cause_q   <= main_lost ? CAUSE_WAKEUP : CAUSE_GENERAL;
        main_lost <= 1'b0;
      end else if (cpu_prev && !main_ok_s) begin
        main_lost <= 1'b1;
      end
    end
  end

  assign bkup_rst_n     = bkup_done;
  assign cpu_rst_n      = cpu_done;
  assign periph_rst_n   = cpu_done;
  assign ext_rst_pulldn = ~ext_done;
  assign rst_cause      = cause_q;

endmodule

// File: rtl/por_reset_seq_chk.sv
module por_reset_seq_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          bkup_por_ok,
  input logic          main_por_ok,
  input logic          bkup_rst_n,
  input logic          cpu_rst_n,
  input logic          periph_rst_n,
  input logic          ext_rst_pulldn,
  input logic [CW-1:0] rst_cause
);

  // R6 and R1: no reset is released while the backup supply is absent.
  assert_bkup_loss_R6: assert property (@(negedge clk)
    !bkup_por_ok |-> (!bkup_rst_n && !cpu_rst_n && !periph_rst_n && ext_rst_pulldn));

  assert_pair_equal_R3: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    cpu_rst_n == periph_rst_n);

  assert_cpu_after_bkup_R3: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    $rose(cpu_rst_n) |-> $past(bkup_rst_n, 3));

  assert_ext_after_bkup_R4: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    !bkup_rst_n |-> ext_rst_pulldn);

  assert_main_drop_R7: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    !main_por_ok |=> !cpu_rst_n);

  assert_bkup_held_R7: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    bkup_rst_n |=> bkup_rst_n);

  assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!bkup_por_ok)
    (rst_cause != $past(rst_cause)) |-> ($past(cpu_rst_n) && !$past(cpu_rst_n, 2)));

endmodule

bind por_reset_seq por_reset_seq_chk #(.CW(3)) u_chk (
  .clk            (clk),
  .bkup_por_ok    (bkup_por_ok),
  .main_por_ok    (main_por_ok),
  .bkup_rst_n     (bkup_rst_n),
  .cpu_rst_n      (cpu_rst_n),
  .periph_rst_n   (periph_rst_n),
  .ext_rst_pulldn (ext_rst_pulldn),
  .rst_cause      (rst_cause)
);

// File: tb/por_reset_seq_tb.sv
module por_reset_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       bkup_por_ok = 1'b0;
  logic       main_por_ok = 1'b0;
  logic [3:0] ext_len = 4'd0;
  logic       bkup_rst_n;
  logic       cpu_rst_n;
  logic       periph_rst_n;
  logic       ext_rst_pulldn;
  logic [2:0] rst_cause;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  por_reset_seq #(
    .STARTUP_CYCLES (STARTUP),
    .HOLD_CYCLES    (3),
    .SYNC_STAGES    (2),
    .LEN_W          (4)
  ) u_dut (
    .clk            (clk),
    .bkup_por_ok    (bkup_por_ok),
    .main_por_ok    (main_por_ok),
    .ext_len        (ext_len),
    .bkup_rst_n     (bkup_rst_n),
    .cpu_rst_n      (cpu_rst_n),
    .periph_rst_n   (periph_rst_n),
    .ext_rst_pulldn (ext_rst_pulldn),
    .rst_cause      (rst_cause)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_all_asserted(input string req);
    check(req, "bkup_rst_n", bkup_rst_n, 0);
    check(req, "cpu_rst_n", cpu_rst_n, 0);
    check(req, "periph_rst_n", periph_rst_n, 0);
    check(req, "ext_rst_pulldn", ext_rst_pulldn, 1);
    check(req, "rst_cause", rst_cause, 0);
  endtask

  // R2 R3 R4 R5: both supplies rise together, stretch setting 0.
  task automatic t_cold_start();
    @(negedge clk);
    ext_len = 4'd0;
    main_por_ok = 1'b1;
    bkup_por_ok = 1'b1;
    tick(STARTUP + 1);
    check("R2", "bkup_rst_n before startup end", bkup_rst_n, 0);
    tick(1);
    check("R2", "bkup_rst_n at startup end", bkup_rst_n, 1);
    tick(1);
    check("R4", "pulldn one edge after backup release", ext_rst_pulldn, 1);
    check("R3", "cpu_rst_n one edge after backup release", cpu_rst_n, 0);
    tick(1);
    check("R4", "pulldn two edges after backup release", ext_rst_pulldn, 0);
    check("R3", "cpu_rst_n two edges after backup release", cpu_rst_n, 0);
    tick(1);
    check("R3", "cpu_rst_n three edges after backup release", cpu_rst_n, 1);
    check("R3", "periph_rst_n three edges after backup release", periph_rst_n, 1);
    tick(1);
    check("R5", "cause after cold start", rst_cause, 0);
  endtask

  // R7 R8 R9: main supply dips while the backup supply stays good.
  task automatic t_main_dip();
    @(negedge clk);
    main_por_ok = 1'b0;
    tick(1);
    check("R7", "cpu_rst_n after main drop", cpu_rst_n, 0);
    check("R7", "periph_rst_n after main drop", periph_rst_n, 0);
    check("R7", "bkup_rst_n after main drop", bkup_rst_n, 1);
    check("R7", "pulldn after main drop", ext_rst_pulldn, 0);
    tick(3);
    check("R9", "cause held during dip", rst_cause, 0);
    @(negedge clk);
    main_por_ok = 1'b1;
    tick(4);
    check("R8", "cpu_rst_n four edges after main return", cpu_rst_n, 0);
    tick(1);
    check("R8", "cpu_rst_n five edges after main return", cpu_rst_n, 1);
    check("R8", "periph_rst_n five edges after main return", periph_rst_n, 1);
    check("R9", "cause held on release edge", rst_cause, 0);
    tick(1);
    check("R8", "cause wake-up after dip", rst_cause, 1);
  endtask

  // R6 R1: backup supply lost while the main supply reports good.
  task automatic t_backup_loss();
    @(negedge clk);
    bkup_por_ok = 1'b0;
    #1;
    check_all_asserted("R6");
    tick(2);
    check_all_asserted("R1");
  endtask

  // R10 R4 R9: main supply late, stretch setting len.
  task automatic t_late_main(input logic [3:0] len);
    int target;
    target = 1 << (int'(len) + 1);
    @(negedge clk);
    ext_len = len;
    main_por_ok = 1'b0;
    bkup_por_ok = 1'b1;
    tick(STARTUP + 2);
    check("R10", "bkup_rst_n released without main", bkup_rst_n, 1);
    tick(target - 1);
    check("R4", "pulldn one edge before stretch end", ext_rst_pulldn, 1);
    tick(1);
    check("R4", "pulldn at stretch end", ext_rst_pulldn, 0);
    check("R10", "cpu_rst_n waits for main", cpu_rst_n, 0);
    @(negedge clk);
    main_por_ok = 1'b1;
    tick(4);
    check("R9", "cpu_rst_n four edges after late main", cpu_rst_n, 0);
    tick(1);
    check("R9", "cpu_rst_n five edges after late main", cpu_rst_n, 1);
    tick(1);
    check("R9", "cause general after late main", rst_cause, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD / 2 + 1);
    check_all_asserted("R1");
    t_cold_start();
    t_main_dip();
    t_backup_loss();
    t_late_main(4'd3);
    t_backup_loss();
    t_late_main(4'd15);
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule